// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Unit

This block resolves read-after-write conflicts in a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it compares the source register numbers of the instruction in execute against the destination numbers carried by the two downstream pipeline registers: the execute/memory latch and the memory/writeback latch. For each ALU operand, and for the store-data path, it produces a 2-bit bypass select. The value on the memory/writeback side is the writeback value, which is the ALU result or the load data. Because registers are read in decode and written in writeback, only read-after-write conflicts can arise. Write-after-read and write-after-write ordering therefore needs no logic.

A load cannot supply its data until the end of the memory stage. When the instruction in decode needs the register that a load in execute is about to fetch, the unit holds the program counter and the fetch/decode latch for one cycle and turns the entry into the decode/execute latch into a bubble. There is one exception: when the dependent instruction is a store and only its data register matches, no stall is needed. In that case the unit raises a late flag in the following cycle. The flag tells the memory stage to take the store data straight from the loaded value in the memory/writeback latch.

Register 0 always reads as zero and never causes a bypass or a stall. A match only counts if the producing instruction writes a register.

Top module: `hz_unit`

## Requirements
- R1: An execute-stage source that equals the execute/memory destination selects code 10 (execute/memory ALU result). This applies when that producer writes a register and the destination is nonzero.
- R2: A source that matches only the memory/writeback destination, with that producer writing a nonzero register, selects code 01 (memory/writeback value).
- R3: When both latches hold a writing producer of the same nonzero source register, the younger execute/memory entry wins and the select is 10.
- R4: With no qualifying match, or with neither producer writing, the select is 00 (register file value).
- R5: Register 0 never produces a nonzero select and never causes a stall, even when a producer names register 0 as its destination.
- R6: Stall condition: a load in execute writes a nonzero register, and the decode instruction uses that register as its first source, or as its second source while not a store. In that case pc_we and ifid_we are 0 and idex_bubble is 1. Otherwise the values are 1, 1 and 0.
- R7: A store in decode whose data register (second source) alone matches a load in execute does not stall. A match on its base register (first source) does stall.
- R8: Store-data select for the instruction in execute: 10 if the execute/memory producer matches and is not a load, 01 if only memory/writeback matches, and 00 otherwise. It is always 00 when the execute instruction is not a store.
- R9: A store in execute whose data register matches a load in execute/memory gets store-data select 00. In the next cycle mem_st_from_load is 1. That flag is 0 in any cycle not preceded by such a match, and 0 after reset.
- R10: A decode source flagged as unused never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | 5 | Decode instruction first source |
| id_rs2 | input | 5 | Decode instruction second source |
| id_use_rs1 | input | 1 | Decode instruction reads first source |
| id_use_rs2 | input | 1 | Decode instruction reads second source |
| id_is_store | input | 1 | Decode instruction is a store |
| ex_rs1 | input | 5 | Execute instruction first source |
| ex_rs2 | input | 5 | Execute instruction second source |
| ex_rd | input | 5 | Execute instruction destination |
| ex_is_store | input | 1 | Execute instruction is a store |
| ex_mem_read | input | 1 | Execute instruction is a load |
| ex_reg_write | input | 1 | Execute instruction writes a register |
| exm_rd | input | 5 | Execute/memory latch destination |
| exm_reg_write | input | 1 | Execute/memory producer writes a register |
| exm_mem_read | input | 1 | Execute/memory producer is a load |
| mwb_rd | input | 5 | Memory/writeback latch destination |
| mwb_reg_write | input | 1 | Memory/writeback producer writes a register |
| fwd_a_sel | output | 2 | ALU operand A select |
| fwd_b_sel | output | 2 | ALU operand B select |
| fwd_st_sel | output | 2 | Store-data select in execute |
| mem_st_from_load | output | 1 | Memory stage takes store data from memory/writeback load data |
| pc_we | output | 1 | Program counter enable |
| ifid_we | output | 1 | Fetch/decode latch enable |
| idex_bubble | output | 1 | Zero control fields entering decode/execute |

## Verification
The assertions check the following on every cycle: the three stall outputs always move together, register 0 and non-writing producers never yield a bypass, and the younger producer always wins a double match. They also check that the store path never picks an execute/memory load and that the late store flag only follows a store. The bench scenarios cover the rest: the exact select codes for each match pattern, the store-in-decode stall exemption against the base-register stall, and the one-cycle timing of the late store flag after reset and across consecutive cycles.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MWB = 2'b01,
    SEL_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int unsigned AW         = 5,
  parameter bit          LOAD_BLOCK = 1'b0
) (
  input  logic [AW-1:0] src,
  input  logic          src_used,
  input  logic [AW-1:0] exm_rd,
  input  logic          exm_wr,
  input  logic          exm_ld,
  input  logic [AW-1:0] mwb_rd,
  input  logic          mwb_wr,
  output fwd_sel_e      sel
);
  logic exm_match;
  logic mwb_match;
  logic exm_usable;

  always_comb begin
    exm_match  = src_used && exm_wr && (exm_rd != '0) && (exm_rd == src);
    mwb_match  = src_used && mwb_wr && (mwb_rd != '0) && (mwb_rd == src);
    exm_usable = exm_match && !(LOAD_BLOCK && exm_ld);
    if (exm_usable)      sel = SEL_EXM;
    else if (exm_match)  sel = SEL_RF;   // stale older value must not win; late path covers it
    else if (mwb_match)  sel = SEL_MWB;
    else                 sel = SEL_RF;
  end
endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse #(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use_rs1,
  input  logic          id_use_rs2,
  input  logic          id_is_store,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_mem_read,
  input  logic          ex_reg_write,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          idex_bubble
);
  logic ld_live;
  logic hit_base;
  logic hit_second;
  logic stall;

  always_comb begin
    ld_live    = ex_mem_read && ex_reg_write && (ex_rd != '0);
    hit_base   = id_use_rs1 && (id_rs1 == ex_rd);
    hit_second = id_use_rs2 && !id_is_store && (id_rs2 == ex_rd);
    stall      = ld_live && (hit_base || hit_second);
    pc_we       = !stall;
    ifid_we     = !stall;
    idex_bubble = stall;
  end

  AST_STALL_TRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we == ifid_we) && (idex_bubble == !pc_we)); // R6

  AST_UNUSED_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_use_rs1 && !id_use_rs2) |-> pc_we); // R10

  AST_R0_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0) |-> !idex_bubble); // R5
endmodule

// File: rtl/hz_store_late.sv
module hz_store_late #(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_is_store,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] exm_rd,
  input  logic          exm_wr,
  input  logic          exm_ld,
  output logic          late_q
);
  logic late_d;

  always_comb begin
    late_d = ex_is_store && exm_ld && exm_wr && (exm_rd != '0) && (exm_rd == ex_rs2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) late_q <= 1'b0;
    else        late_q <= late_d;
  end

  AST_LATE_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    late_q |-> $past(ex_is_store)); // R9
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use_rs1,
  input  logic          id_use_rs2,
  input  logic          id_is_store,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_is_store,
  input  logic          ex_mem_read,
  input  logic          ex_reg_write,
  input  logic [AW-1:0] exm_rd,
  input  logic          exm_reg_write,
  input  logic          exm_mem_read,
  input  logic [AW-1:0] mwb_rd,
  input  logic          mwb_reg_write,
  output logic [1:0]    fwd_a_sel,
  output logic [1:0]    fwd_b_sel,
  output logic [1:0]    fwd_st_sel,
  output logic          mem_st_from_load,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          idex_bubble
);
  localparam int unsigned NPATH = 3;  // operand A, operand B, store data

  logic [AW-1:0] path_src  [NPATH];
  logic          path_used [NPATH];
  fwd_sel_e      path_sel  [NPATH];

  always_comb begin
    path_src[0]  = ex_rs1;
    path_src[1]  = ex_rs2;
    path_src[2]  = ex_rs2;
    path_used[0] = 1'b1;
    path_used[1] = 1'b1;
    path_used[2] = ex_is_store;
  end

  for (genvar k = 0; k < NPATH; k++) begin : g_path
    hz_fwd_pick #(
      .AW         (AW),
      .LOAD_BLOCK (k == NPATH - 1)
    ) u_pick (
      .src      (path_src[k]),
      .src_used (path_used[k]),
      .exm_rd   (exm_rd),
      .exm_wr   (exm_reg_write),
      .exm_ld   (exm_mem_read),
      .mwb_rd   (mwb_rd),
      .mwb_wr   (mwb_reg_write),
      .sel      (path_sel[k])
    );
  end

  always_comb begin
    fwd_a_sel  = path_sel[0];
    fwd_b_sel  = path_sel[1];
    fwd_st_sel = path_sel[2];
  end

  hz_loaduse #(.AW(AW)) u_loaduse (
    .clk          (clk),
    .rst_n        (rst_n),
    .id_rs1       (id_rs1),
    .id_rs2       (id_rs2),
    .id_use_rs1   (id_use_rs1),
    .id_use_rs2   (id_use_rs2),
    .id_is_store  (id_is_store),
    .ex_rd        (ex_rd),
    .ex_mem_read  (ex_mem_read),
    .ex_reg_write (ex_reg_write),
    .pc_we        (pc_we),
    .ifid_we      (ifid_we),
    .idex_bubble  (idex_bubble)
  );

  hz_store_late #(.AW(AW)) u_store_late (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_is_store (ex_is_store),
    .ex_rs2      (ex_rs2),
    .exm_rd      (exm_rd),
    .exm_wr      (exm_reg_write),
    .exm_ld      (exm_mem_read),
    .late_q      (mem_st_from_load)
  );

  AST_R0_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == '0) |-> (fwd_a_sel == SEL_RF)); // R5

  AST_YOUNGER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (exm_reg_write && mwb_reg_write && exm_rd == mwb_rd && exm_rd == ex_rs1 && ex_rs1 != '0)
      |-> (fwd_a_sel == SEL_EXM)); // R3

  AST_NO_WRITER_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (!exm_reg_write && !mwb_reg_write) |-> (fwd_a_sel == SEL_RF && fwd_b_sel == SEL_RF)); // R4

  AST_ST_NOT_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_st_sel == SEL_EXM) |-> !exm_mem_read); // R8
endmodule

// File: tb/hz_unit_tb.sv
module hz_unit_tb;
  typedef struct packed {
    logic [4:0] id_rs1; logic [4:0] id_rs2; logic u1; logic u2; logic id_st;
    logic [4:0] ex_rs1; logic [4:0] ex_rs2; logic [4:0] ex_rd;
    logic ex_st; logic ex_mr; logic ex_rw;
    logic [4:0] exm_rd; logic exm_rw; logic exm_mr;
    logic [4:0] mwb_rd; logic mwb_rw;
    logic [1:0] e_a; logic [1:0] e_b; logic [1:0] e_s; logic e_stall;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // id_rs1 id_rs2 u1 u2 st | ex_rs1 ex_rs2 ex_rd st mr rw | exm rd rw mr | mwb rd rw | a b s stall req
    '{0,0,0,0,0, 3,4,0,0,0,0, 3,1,0, 0,0, 2,0,0,0, 1},  // R1 operand A
    '{0,0,0,0,0, 1,4,0,0,0,0, 4,1,0, 0,0, 0,2,0,0, 1},  // R1 operand B
    '{0,0,0,0,0, 7,2,0,0,0,0, 0,0,0, 7,1, 1,0,0,0, 2},  // R2
    '{0,0,0,0,0, 5,5,0,0,0,0, 5,1,0, 5,1, 2,2,0,0, 3},  // R3
    '{0,0,0,0,0, 6,6,0,0,0,0, 6,0,0, 6,0, 0,0,0,0, 4},  // R4
    '{0,0,0,0,0, 0,0,0,0,0,0, 0,1,0, 0,1, 0,0,0,0, 5},  // R5 forwarding
    '{8,0,1,0,0, 0,0,8,0,1,1, 0,0,0, 0,0, 0,0,0,1, 6},  // R6 first source
    '{0,8,0,1,0, 0,0,8,0,1,1, 0,0,0, 0,0, 0,0,0,1, 6},  // R6 second source
    '{2,8,1,1,1, 0,0,8,0,1,1, 0,0,0, 0,0, 0,0,0,0, 7},  // R7 store data no stall
    '{8,3,1,1,1, 0,0,8,0,1,1, 0,0,0, 0,0, 0,0,0,1, 7},  // R7 store base stalls
    '{8,0,0,0,0, 0,0,8,0,1,1, 0,0,0, 0,0, 0,0,0,0, 10}, // R10
    '{0,0,1,0,0, 0,0,0,0,1,1, 0,0,0, 0,0, 0,0,0,0, 5},  // R5 stall
    '{8,0,1,0,0, 0,0,8,0,0,1, 0,0,0, 0,0, 0,0,0,0, 6},  // R6 non-load
    '{0,0,0,0,0, 1,9,0,1,0,0, 9,1,0, 0,0, 0,2,2,0, 8},  // R8 from EX/MEM
    '{0,0,0,0,0, 1,9,0,1,0,0, 0,0,0, 9,1, 0,1,1,0, 8},  // R8 from MEM/WB
    '{0,0,0,0,0, 1,9,0,0,0,0, 9,1,0, 0,0, 0,2,0,0, 8},  // R8 non-store
    '{0,0,0,0,0, 1,9,0,1,0,0, 9,1,1, 9,1, 0,2,0,0, 9}   // R9 load in EX/MEM
  };

  logic clk, rst_n;
  logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, exm_rd, mwb_rd;
  logic id_use_rs1, id_use_rs2, id_is_store, ex_is_store, ex_mem_read, ex_reg_write;
  logic exm_reg_write, exm_mem_read, mwb_reg_write;
  logic [1:0] fwd_a_sel, fwd_b_sel, fwd_st_sel;
  logic mem_st_from_load, pc_we, ifid_we, idex_bubble;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  hz_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .id_is_store(id_is_store),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_is_store(ex_is_store),
    .ex_mem_read(ex_mem_read), .ex_reg_write(ex_reg_write),
    .exm_rd(exm_rd), .exm_reg_write(exm_reg_write), .exm_mem_read(exm_mem_read),
    .mwb_rd(mwb_rd), .mwb_reg_write(mwb_reg_write),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .fwd_st_sel(fwd_st_sel),
    .mem_st_from_load(mem_st_from_load), .pc_we(pc_we), .ifid_we(ifid_we),
    .idex_bubble(idex_bubble)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    id_rs1 = v.id_rs1; id_rs2 = v.id_rs2; id_use_rs1 = v.u1; id_use_rs2 = v.u2;
    id_is_store = v.id_st;
    ex_rs1 = v.ex_rs1; ex_rs2 = v.ex_rs2; ex_rd = v.ex_rd; ex_is_store = v.ex_st;
    ex_mem_read = v.ex_mr; ex_reg_write = v.ex_rw;
    exm_rd = v.exm_rd; exm_reg_write = v.exm_rw; exm_mem_read = v.exm_mr;
    mwb_rd = v.mwb_rd; mwb_reg_write = v.mwb_rw;
  endtask

  task automatic check_stall(input string req, input logic s);
    chk(req, "pc_we", int'(pc_we), int'(!s));
    chk(req, "ifid_we", int'(ifid_we), int'(!s));
    chk(req, "idex_bubble", int'(idex_bubble), int'(s));
  endtask

  initial begin
    vec_t z;
    string rq;
    z = '0;
    rst_n = 1'b0;
    apply(z);
    repeat (3) @(negedge clk);
    // Reset state (R9, R4, R6)
    chk("R9", "late flag in reset", int'(mem_st_from_load), 0);
    chk("R4", "fwd_a idle", int'(fwd_a_sel), 0);
    check_stall("R6", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      #2;
      rq = $sformatf("R%0d", VECS[i].req);
      chk(rq, "fwd_a_sel", int'(fwd_a_sel), int'(VECS[i].e_a));
      chk(rq, "fwd_b_sel", int'(fwd_b_sel), int'(VECS[i].e_b));
      chk(rq, "fwd_st_sel", int'(fwd_st_sel), int'(VECS[i].e_s));
      check_stall(rq, VECS[i].e_stall);
      @(negedge clk);
    end

    // R9: late flag timing, store after a matching load
    apply(z);
    @(negedge clk);
    chk("R9", "late flag idle", int'(mem_st_from_load), 0);
    apply(VECS[NV-1]);
    @(negedge clk);
    chk("R9", "late flag one cycle after match", int'(mem_st_from_load), 1);
    apply(z);
    @(negedge clk);
    chk("R9", "late flag clears", int'(mem_st_from_load), 0);
    // R9: back-to-back matches hold the flag for consecutive cycles
    apply(VECS[NV-1]);
    @(negedge clk);
    @(negedge clk);
    chk("R9", "late flag consecutive", int'(mem_st_from_load), 1);
    // R9: matching load but non-store in EX gives no flag
    z.ex_rs2 = 5'd9; z.exm_rd = 5'd9; z.exm_rw = 1'b1; z.exm_mr = 1'b1;
    apply(z);
    @(negedge clk);
    chk("R9", "late flag non-store", int'(mem_st_from_load), 0);
    // R9: reset clears the flag
    apply(VECS[NV-1]);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R9", "late flag async reset", int'(mem_st_from_load), 0);
    rst_n = 1'b1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule